// File: doc/BRIEF.md
# Trap Entry and Return Controller

This block makes the control decisions a simple processor needs when it enters and leaves its exception handlers. Each cycle it looks at two synchronous trap requests from the instruction in execution (undefined opcode, arithmetic overflow), one asynchronous interrupt line, the current program counter and a return strobe. It then decides whether to enter a handler, return from one, or do nothing.

On entry the controller stores a cause code and the interrupted PC. It pushes the current privilege mode onto a one-deep stack, switches to kernel mode and masks interrupts. It also raises a one-cycle redirect with the handler address. The address comes from one of two schemes, chosen by an input. The single-entry scheme sends every cause to one fixed handler. The vectored scheme gives each cause its own 32-instruction slot. A return pops the saved mode, unmasks interrupts and redirects to the stored PC. All three changes happen in the same cycle.

Top module: `trap_ctrl`

## Requirements
- R1: After reset, redirect is low, kernel mode is set, interrupts are disabled, and both the cause and the saved PC read 0.
- R2: The cause register records the winning request one cycle after it is sampled. The codes are undefined instruction = 0, arithmetic overflow = 1 and interrupt = 2.
- R3: On entry the saved PC takes the value of `pc_i` from the request cycle. In the following cycle the mode reads kernel (`kernel_o` = 1) and interrupts read disabled (`ie_o` = 0).
- R4: In single-entry mode (`vec_mode_i` = 0), `redirect_o` is high for exactly the cycle after an entry, and `target_o` is 0x80000080.
- R5: In vectored mode (`vec_mode_i` = 1) the entry target is 0x80 + (cause << 7). This gives 0x80, 0x100 and 0x180 for the three causes.
- R6: An interrupt request is taken only while `ie_o` is 1. Otherwise it is ignored: no redirect, and the cause, saved PC and mode are all unchanged.
- R7: Requests are ranked from highest to lowest as: undefined instruction, overflow, enabled interrupt, return. Only the highest-ranked request present acts.
- R8: A return that wins raises `redirect_o` in the next cycle, with `target_o` equal to the saved PC. In that same cycle the mode becomes the stacked mode and `ie_o` becomes 1. Out of reset the stacked mode is user (0), so the first return enters user mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| undef_i | input | 1 | Undefined-instruction trap request |
| ovf_i | input | 1 | Arithmetic-overflow trap request |
| irq_i | input | 1 | Asynchronous interrupt request (level) |
| eret_i | input | 1 | Return-from-exception strobe |
| vec_mode_i | input | 1 | 1 selects vectored handler addresses |
| pc_i | input | XLEN | PC of the current instruction |
| redirect_o | output | 1 | Fetch redirect strobe |
| target_o | output | XLEN | Redirect address |
| cause_o | output | 2 | Latched cause code |
| epc_o | output | XLEN | Saved return PC |
| kernel_o | output | 1 | 1 = kernel mode |
| ie_o | output | 1 | Interrupt enable |

## Verification
The bench applies every combination of the four request inputs in both addressing modes. It does this from two starting states: the reset state (kernel, interrupts off) and user mode with interrupts on after a first return. The combinations with several requests at once show whether the ranking is correct. The interrupt-only case with interrupts off shows whether masking holds. After each combination a lone return and an idle cycle follow. These check that the stacked mode is restored, that the target equals the captured PC, and that the redirect drops after one cycle.

// File: rtl/trap_pkg.sv
package trap_pkg;
   localparam int CAUSE_W = 2;
   typedef enum logic [CAUSE_W-1:0] {
      CAUSE_UNDEF = 2'd0,
      CAUSE_OVF   = 2'd1,
      CAUSE_IRQ   = 2'd2
   } cause_e;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
   import trap_pkg::*;
(
   input  logic   undef_i,
   input  logic   ovf_i,
   input  logic   irq_i,
   input  logic   ie_i,
   input  logic   eret_i,
   output logic   enter_o,
   output logic   leave_o,
   output cause_e code_o
);
   logic irq_ok;

   always_comb begin
      irq_ok  = irq_i & ie_i;
      enter_o = undef_i | ovf_i | irq_ok;
      leave_o = eret_i & ~enter_o;
      if (undef_i)     code_o = CAUSE_UNDEF;
      else if (ovf_i)  code_o = CAUSE_OVF;
      else             code_o = CAUSE_IRQ;
   end
endmodule

// File: rtl/trap_vector.sv
module trap_vector
   import trap_pkg::*;
#(
   parameter int              XLEN       = 32,
   parameter bit              VEC_ENABLE = 1'b1,
   parameter logic [XLEN-1:0] FIXED_ADDR = 32'h8000_0080,
   parameter logic [XLEN-1:0] VEC_BASE   = 32'h0000_0080,
   parameter int              VEC_SHIFT  = 7
) (
   input  logic            vec_mode_i,
   input  cause_e          code_i,
   output logic [XLEN-1:0] target_o
);
   localparam int SLOT_TOP = VEC_SHIFT + CAUSE_W;

   initial begin
      if (SLOT_TOP > XLEN) $error("vector slot field exceeds address width");
   end

   generate
      if (VEC_ENABLE) begin : g_vectored
         logic [XLEN-1:0] slot;
         always_comb begin
            slot     = XLEN'(code_i) << VEC_SHIFT;
            target_o = vec_mode_i ? (VEC_BASE + slot) : FIXED_ADDR;
         end
      end else begin : g_fixed
         logic unused_sel;
         always_comb begin
            unused_sel = vec_mode_i ^ code_i[0];
            target_o   = FIXED_ADDR;
         end
      end
   endgenerate
endmodule

// File: rtl/trap_state.sv
module trap_state
   import trap_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enter_i,
   input  logic            leave_i,
   input  cause_e          code_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic [XLEN-1:0] entry_tgt_i,
   output logic            redirect_o,
   output logic [XLEN-1:0] target_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [XLEN-1:0] epc_o,
   output logic            kernel_o,
   output logic            ie_o
);
   logic prev_kernel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         redirect_o    <= 1'b0;
         target_o      <= '0;
         cause_o       <= '0;
         epc_o         <= '0;
         kernel_o      <= 1'b1;
         ie_o          <= 1'b0;
         prev_kernel_q <= 1'b0;
      end else if (enter_i) begin
         redirect_o    <= 1'b1;
         target_o      <= entry_tgt_i;
         cause_o       <= code_i;
         epc_o         <= pc_i;
         prev_kernel_q <= kernel_o;
         kernel_o      <= 1'b1;
         ie_o          <= 1'b0;
      end else if (leave_i) begin
         redirect_o    <= 1'b1;
         target_o      <= epc_o;
         kernel_o      <= prev_kernel_q;
         ie_o          <= 1'b1;
      end else begin
         redirect_o    <= 1'b0;
      end
   end

   AST_ENTRY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      enter_i |=> kernel_o && !ie_o && redirect_o); // R3
   AST_EPC_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      enter_i |=> epc_o == $past(pc_i)); // R3
   AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      leave_i |=> redirect_o && ie_o && target_o == $past(epc_o)); // R8
   AST_REDIR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !enter_i && !leave_i |=> !redirect_o); // R4
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
   import trap_pkg::*;
#(
   parameter int              XLEN       = 32,
   parameter bit              VEC_ENABLE = 1'b1,
   parameter logic [XLEN-1:0] FIXED_ADDR = 32'h8000_0080,
   parameter logic [XLEN-1:0] VEC_BASE   = 32'h0000_0080,
   parameter int              VEC_SHIFT  = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               undef_i,
   input  logic               ovf_i,
   input  logic               irq_i,
   input  logic               eret_i,
   input  logic               vec_mode_i,
   input  logic [XLEN-1:0]    pc_i,
   output logic               redirect_o,
   output logic [XLEN-1:0]    target_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [XLEN-1:0]    epc_o,
   output logic               kernel_o,
   output logic               ie_o
);
   initial begin
      if (XLEN < 8) $error("XLEN too small for handler addresses");
   end

   logic            enter, leave;
   cause_e          code;
   logic [XLEN-1:0] entry_tgt;

   trap_arbiter u_arb (
      .undef_i (undef_i),
      .ovf_i   (ovf_i),
      .irq_i   (irq_i),
      .ie_i    (ie_o),
      .eret_i  (eret_i),
      .enter_o (enter),
      .leave_o (leave),
      .code_o  (code)
   );

   trap_vector #(
      .XLEN       (XLEN),
      .VEC_ENABLE (VEC_ENABLE),
      .FIXED_ADDR (FIXED_ADDR),
      .VEC_BASE   (VEC_BASE),
      .VEC_SHIFT  (VEC_SHIFT)
   ) u_vec (
      .vec_mode_i (vec_mode_i),
      .code_i     (code),
      .target_o   (entry_tgt)
   );

   trap_state #(.XLEN(XLEN)) u_state (
      .clk         (clk),
      .rst_n       (rst_n),
      .enter_i     (enter),
      .leave_i     (leave),
      .code_i      (code),
      .pc_i        (pc_i),
      .entry_tgt_i (entry_tgt),
      .redirect_o  (redirect_o),
      .target_o    (target_o),
      .cause_o     (cause_o),
      .epc_o       (epc_o),
      .kernel_o    (kernel_o),
      .ie_o        (ie_o)
   );

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_i && !ie_o && !undef_i && !ovf_i && !eret_i |=> !redirect_o); // R6
   AST_FIXED_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (undef_i || ovf_i) && !vec_mode_i |=> target_o == FIXED_ADDR); // R4
   AST_UNDEF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      undef_i |=> cause_o == CAUSE_W'(0)); // R7
endmodule

// File: tb/trap_ctrl_test.sv
module trap_ctrl_test;
   localparam int XLEN = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            undef_i = 1'b0, ovf_i = 1'b0, irq_i = 1'b0, eret_i = 1'b0;
   logic            vec_mode_i = 1'b0;
   logic [XLEN-1:0] pc_i = '0;
   logic            redirect_o;
   logic [XLEN-1:0] target_o;
   logic [1:0]      cause_o;
   logic [XLEN-1:0] epc_o;
   logic            kernel_o, ie_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // expected state
   logic            m_red, m_k, m_ie, m_pk;
   logic [XLEN-1:0] m_tgt, m_epc;
   logic [1:0]      m_cause;

   always #5 clk = ~clk;

   trap_ctrl uut (
      .clk(clk), .rst_n(rst_n), .undef_i(undef_i), .ovf_i(ovf_i), .irq_i(irq_i),
      .eret_i(eret_i), .vec_mode_i(vec_mode_i), .pc_i(pc_i),
      .redirect_o(redirect_o), .target_o(target_o), .cause_o(cause_o),
      .epc_o(epc_o), .kernel_o(kernel_o), .ie_o(ie_o)
   );

   task automatic chk(input string tag, input string what,
                      input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag, input string tgt_tag);
      chk(tag, "redirect", XLEN'(redirect_o), XLEN'(m_red));
      if (m_red) chk(tgt_tag, "target", target_o, m_tgt);
      chk(tag, "kernel", XLEN'(kernel_o), XLEN'(m_k));
      chk(tag, "ie", XLEN'(ie_o), XLEN'(m_ie));
      chk(tag, "epc", epc_o, m_epc);
      chk("R2", "cause", XLEN'(cause_o), XLEN'(m_cause));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; undef_i = 0; ovf_i = 0; irq_i = 0; eret_i = 0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_red = 0; m_k = 1; m_ie = 0; m_pk = 0; m_tgt = '0; m_epc = '0; m_cause = 0;
      compare("R1", "R1");
   endtask

   // apply one request pattern for one cycle and check the following cycle
   task automatic step(input logic u, input logic o, input logic i, input logic e,
                       input logic [XLEN-1:0] pc, input string tag);
      logic ent, ret;
      logic [1:0] code;
      undef_i = u; ovf_i = o; irq_i = i; eret_i = e; pc_i = pc;
      @(posedge clk);
      ent  = u | o | (i & m_ie);
      ret  = e & ~ent;
      code = u ? 2'd0 : (o ? 2'd1 : 2'd2);
      if (ent) begin
         m_pk = m_k; m_k = 1; m_ie = 0; m_epc = pc; m_cause = code; m_red = 1;
         m_tgt = vec_mode_i ? (32'h80 + (XLEN'(code) << 7)) : 32'h8000_0080;
      end else if (ret) begin
         m_k = m_pk; m_ie = 1; m_red = 1; m_tgt = m_epc;
      end else begin
         m_red = 0;
      end
      @(negedge clk);
      compare(tag, vec_mode_i ? "R5" : "R4");
   endtask

   initial begin
      for (int vm = 0; vm < 2; vm++) begin
         for (int st = 0; st < 2; st++) begin
            for (int combo = 0; combo < 16; combo++) begin
               string tag;
               logic u, o, i, e;
               u = combo[0]; o = combo[1]; i = combo[2]; e = combo[3];
               vec_mode_i = vm[0];
               do_reset();
               if (st == 1) step(0, 0, 0, 1, 32'h0, "R8");   // drop to user, IE on
               if (i && st == 0 && !u && !o)      tag = "R6";
               else if ($countones({u, o, i, e}) > 1) tag = "R7";
               else if (e)                         tag = "R8";
               else                                tag = "R3";
               step(u, o, i, e, 32'h0000_1000 + 32'(combo * 16 + st * 4 + vm * 512), tag);
               step(0, 0, 0, 1, 32'h0000_dead, "R8");
               step(0, 0, 0, 0, 32'h0000_beef, "R4");
            end
         end
      end
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule